// File: doc/BRIEF.md
# Sixteen-bit arithmetic unit with overflow word

This block is the execute stage of a small 16-bit word machine. Each operation takes a 4-bit opcode and two 16-bit operands, `a` and `b`. Within the same cycle it returns three things: the 16-bit value to write back to the `a` destination, whether the opcode is one this unit handles, and how many machine cycles the operation costs.

Arithmetic operations also produce a second 16-bit word, the overflow word. Its contents depend on the operation: a carry or borrow flag, the upper half of a product, the fraction from a divide, or the bits pushed out by a shift. The overflow word is a register held inside the block. It changes only on a rising clock edge while `validIn` is high.

The surrounding machine can also name the overflow register as an operand. To read it, the operand fetch logic uses `ovfWord`. To write it, the machine raises `dstIsOvf`, and the write-back result then replaces the overflow word. Division and modulo by zero have defined results and do not trap.

Top module: `ovf_alu`

## Requirements
- R1: Add (opcode 0x2) returns the low 16 bits of a+b. Its overflow word becomes 1 when the full sum exceeds 0xFFFF and 0 otherwise.
- R2: Subtract (opcode 0x3) returns the low 16 bits of a-b. Its overflow word becomes 1 when a < b and 0 otherwise.
- R3: Multiply (opcode 0x4) returns bits 15:0 of the 32-bit product a*b. Its overflow word becomes bits 31:16 of that product.
- R4: Divide (opcode 0x5) with b nonzero returns a/b truncated, and the overflow word becomes the low 16 bits of (a*65536)/b. With b = 0, both the result and the overflow word are 0.
- R5: Modulo (opcode 0x6) returns a mod b, or 0 when b = 0. It never changes the overflow word.
- R6: Shift left (opcode 0x7) returns bits 15:0 of a shifted left by b, and the overflow word becomes bits 31:16 of that 32-bit shifted value. When b >= 32, both are 0.
- R7: Shift right (opcode 0x8) returns a shifted right by b. The overflow word becomes the low 16 bits of (a*65536) shifted right by b. When b >= 32, both are 0.
- R8: Set (0x1), AND (0x9), OR (0xA) and XOR (0xB) return b, a&b, a|b and a^b. None of them changes the overflow word.
- R9: `cost` is 1 for set, AND, OR and XOR. It is 2 for add, subtract, multiply and both shifts, and 3 for divide and modulo.
- R10: Opcodes 0x0 and 0xC to 0xF drive `handled` low, `result` to 0 and `cost` to 0. They leave the overflow word unchanged even when `dstIsOvf` is high.
- R11: The overflow word changes only on a rising clock edge with `validIn` high. With `validIn` low it holds its value.
- R12: When `dstIsOvf` is high on a valid handled operation, the overflow word takes `result`. This overrides any overflow value the operation itself produces.
- R13: After reset the overflow word is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| validIn | input | 1 | Operation present this cycle; commits the overflow update |
| opcode | input | 4 | Basic operation code |
| opA | input | 16 | Operand a (current destination value) |
| opB | input | 16 | Operand b |
| dstIsOvf | input | 1 | Destination of the write-back is the overflow register |
| result | output | 16 | Value to write back to the destination |
| cost | output | 2 | Machine cycle cost of the operation |
| handled | output | 1 | Opcode is one this unit executes |
| ovfWord | output | 16 | Current overflow register value |

## Verification
The bench goes after five edge cases:

- **Divide by zero.** A unit that divides anyway produces all-ones garbage in both outputs.
- **Modulo by zero.** A unit that lets modulo write the overflow word clobbers the word the previous operation left.
- **Shift amounts of 16 to 31 and 32 or more.** A narrow shifter loses the spilled bits, or wraps the amount and returns a nonzero value.
- **Subtract and add carry edges.** This covers a = b, a < b by one, and a sum of exactly 0x10000. A wrong width on these leaves the flag stuck.
- **Overriding destination and disabled strobe.** When the overflow register is the destination, the write-back must replace the flag value. A missing priority shows up as the flag value left in the register. An operation with `validIn` low must leave the word untouched.

// File: rtl/ovf_alu_pkg.sv
package ovf_alu_pkg;

  typedef enum logic [3:0] {
    SEL_NONE = 4'h0,
    SEL_SET  = 4'h1,
    SEL_ADD  = 4'h2,
    SEL_SUB  = 4'h3,
    SEL_MUL  = 4'h4,
    SEL_DIV  = 4'h5,
    SEL_MOD  = 4'h6,
    SEL_SHL  = 4'h7,
    SEL_SHR  = 4'h8,
    SEL_AND  = 4'h9,
    SEL_OR   = 4'hA,
    SEL_XOR  = 4'hB
  } aluSelE;

  typedef struct packed {
    aluSelE     sel;
    logic       known;
    logic [1:0] cost;
    logic       loadOvf;
    logic       loadRes;
  } aluCtrlT;

endpackage

// File: rtl/ovf_alu_ctrl.sv
module ovf_alu_ctrl
  import ovf_alu_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       validIn,
  input  logic [3:0] opcode,
  input  logic       dstIsOvf,
  output aluCtrlT    ctl
);

  aluSelE     sel;
  logic       known;
  logic       writesOvf;
  logic [1:0] cost;

  always_comb begin
    sel       = SEL_NONE;
    known     = 1'b1;
    writesOvf = 1'b0;
    cost      = 2'd0;
    unique case (opcode)
      4'h1: begin sel = SEL_SET; cost = 2'd1; end
      4'h2: begin sel = SEL_ADD; cost = 2'd2; writesOvf = 1'b1; end
      4'h3: begin sel = SEL_SUB; cost = 2'd2; writesOvf = 1'b1; end
      4'h4: begin sel = SEL_MUL; cost = 2'd2; writesOvf = 1'b1; end
      4'h5: begin sel = SEL_DIV; cost = 2'd3; writesOvf = 1'b1; end
      4'h6: begin sel = SEL_MOD; cost = 2'd3; end
      4'h7: begin sel = SEL_SHL; cost = 2'd2; writesOvf = 1'b1; end
      4'h8: begin sel = SEL_SHR; cost = 2'd2; writesOvf = 1'b1; end
      4'h9: begin sel = SEL_AND; cost = 2'd1; end
      4'hA: begin sel = SEL_OR;  cost = 2'd1; end
      4'hB: begin sel = SEL_XOR; cost = 2'd1; end
      default: known = 1'b0;
    endcase
  end

  always_comb begin
    ctl.sel     = sel;
    ctl.known   = known;
    ctl.cost    = cost;
    ctl.loadRes = validIn & known & dstIsOvf;
    ctl.loadOvf = validIn & known & writesOvf & ~dstIsOvf;
  end

  // R9
  cost_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.known |-> (ctl.cost != 2'd0));

  // R10
  unknown_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.known |-> (!ctl.loadOvf && !ctl.loadRes && ctl.cost == 2'd0));

  // R5
  mod_keeps_ovf_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.sel == SEL_MOD) |-> !ctl.loadOvf);

  // R12
  dst_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(ctl.loadOvf && ctl.loadRes));

endmodule

// File: rtl/ovf_alu_dp.sv
module ovf_alu_dp
  import ovf_alu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  aluCtrlT      ctl,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  output logic [W-1:0] result,
  output logic [W-1:0] ovfWord
);

  localparam int W2  = 2 * W;
  localparam int SHW = $clog2(W2);

  logic [W2-1:0] wideA, wideB, sumW, diffW, prodW, fracW, shlW, shrW;
  logic [W-1:0]  ovfNext;
  logic          bZero, bigShift;
  logic [SHW-1:0] amt;

  assign wideA    = {{W{1'b0}}, opA};
  assign wideB    = {{W{1'b0}}, opB};
  assign bZero    = (opB == '0);
  assign bigShift = |opB[W-1:SHW];
  assign amt      = opB[SHW-1:0];

  assign sumW  = wideA + wideB;
  assign diffW = wideA - wideB;
  assign prodW = wideA * wideB;
  assign fracW = bZero ? '0 : ({opA, {W{1'b0}}} / wideB);
  assign shlW  = bigShift ? '0 : (wideA << amt);
  assign shrW  = bigShift ? '0 : ({opA, {W{1'b0}}} >> amt);

  always_comb begin
    result  = '0;
    ovfNext = '0;
    unique case (ctl.sel)
      SEL_SET: result = opB;
      SEL_ADD: begin result = sumW[W-1:0];  ovfNext = {{(W-1){1'b0}}, sumW[W]}; end
      SEL_SUB: begin result = diffW[W-1:0]; ovfNext = {{(W-1){1'b0}}, diffW[W2-1]}; end
      SEL_MUL: begin result = prodW[W-1:0]; ovfNext = prodW[W2-1:W]; end
      SEL_DIV: begin
        result  = bZero ? '0 : (opA / opB);
        ovfNext = fracW[W-1:0];
      end
      SEL_MOD: result = bZero ? '0 : (opA % opB);
      SEL_SHL: begin result = shlW[W-1:0];    ovfNext = shlW[W2-1:W]; end
      SEL_SHR: begin result = shrW[W2-1:W];   ovfNext = shrW[W-1:0]; end
      SEL_AND: result = opA & opB;
      SEL_OR:  result = opA | opB;
      SEL_XOR: result = opA ^ opB;
      default: result = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            ovfWord <= '0;
    else if (ctl.loadRes) ovfWord <= result;
    else if (ctl.loadOvf) ovfWord <= ovfNext;
  end

  // R4
  div_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.sel == SEL_DIV && bZero) |-> (result == '0 && ovfNext == '0));

  // R6
  shl_big_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.sel == SEL_SHL && bigShift) |-> (result == '0 && ovfNext == '0));

  // R7
  shr_big_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.sel == SEL_SHR && bigShift) |-> (result == '0 && ovfNext == '0));

  // R11
  ovf_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(ctl.loadOvf || ctl.loadRes) |=> $stable(ovfWord));

endmodule

// File: rtl/ovf_alu.sv
module ovf_alu
  import ovf_alu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         validIn,
  input  logic [3:0]   opcode,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  logic         dstIsOvf,
  output logic [W-1:0] result,
  output logic [1:0]   cost,
  output logic         handled,
  output logic [W-1:0] ovfWord
);

  aluCtrlT ctl;

  ovf_alu_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .validIn  (validIn),
    .opcode   (opcode),
    .dstIsOvf (dstIsOvf),
    .ctl      (ctl)
  );

  ovf_alu_dp #(.W(W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .opA     (opA),
    .opB     (opB),
    .result  (result),
    .ovfWord (ovfWord)
  );

  assign cost    = ctl.cost;
  assign handled = ctl.known;

  // R10
  unhandled_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !handled |-> (result == '0));

endmodule

// File: tb/ovf_alu_bench.sv
module ovf_alu_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        validIn = 1'b0;
  logic [3:0]  opcode = 4'h0;
  logic [15:0] opA = '0, opB = '0;
  logic        dstIsOvf = 1'b0;
  logic [15:0] result, ovfWord;
  logic [1:0]  cost;
  logic        handled;

  int errors = 0;
  int checks = 0;
  logic [15:0] expOvf = '0;

  always #10 clk = ~clk;

  ovf_alu u_ovf_alu (
    .clk(clk), .rstN(rstN), .validIn(validIn), .opcode(opcode),
    .opA(opA), .opB(opB), .dstIsOvf(dstIsOvf),
    .result(result), .cost(cost), .handled(handled), .ovfWord(ovfWord)
  );

  function automatic string reqOf(input logic [3:0] op);
    case (op)
      4'h2: return "R1";
      4'h3: return "R2";
      4'h4: return "R3";
      4'h5: return "R4";
      4'h6: return "R5";
      4'h7: return "R6";
      4'h8: return "R7";
      4'h1, 4'h9, 4'hA, 4'hB: return "R8";
      default: return "R10";
    endcase
  endfunction

  task automatic model(input logic [3:0] op, input logic [15:0] a, input logic [15:0] b,
                       output logic [15:0] r, output logic [15:0] ov, output logic wr,
                       output logic [1:0] c, output logic h);
    logic [31:0] t;
    r = '0; ov = '0; wr = 1'b0; c = 2'd0; h = 1'b1;
    case (op)
      4'h1: begin r = b; c = 1; end
      4'h2: begin t = 32'(a) + 32'(b); r = t[15:0]; ov = (t > 32'hFFFF) ? 16'd1 : 16'd0; wr = 1; c = 2; end
      4'h3: begin r = a - b; ov = (a < b) ? 16'd1 : 16'd0; wr = 1; c = 2; end
      4'h4: begin t = 32'(a) * 32'(b); r = t[15:0]; ov = t[31:16]; wr = 1; c = 2; end
      4'h5: begin
        wr = 1; c = 3;
        if (b != 0) begin r = a / b; t = (32'(a) * 32'd65536) / 32'(b); ov = t[15:0]; end
      end
      4'h6: begin c = 3; r = (b == 0) ? 16'd0 : a % b; end
      4'h7: begin
        wr = 1; c = 2;
        if (b < 32) begin t = 32'(a) << b; r = t[15:0]; ov = t[31:16]; end
      end
      4'h8: begin
        wr = 1; c = 2;
        if (b < 32) begin r = (b >= 16) ? 16'd0 : (a >> b); t = (32'(a) * 32'd65536) >> b; ov = t[15:0]; end
      end
      4'h9: begin r = a & b; c = 1; end
      4'hA: begin r = a | b; c = 1; end
      4'hB: begin r = a ^ b; c = 1; end
      default: h = 1'b0;
    endcase
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic doOp(input logic [3:0] op, input logic [15:0] a, input logic [15:0] b,
                      input logic dst, input logic vld);
    logic [15:0] r, ov;
    logic wr, h;
    logic [1:0] c;
    @(negedge clk);
    opcode = op; opA = a; opB = b; dstIsOvf = dst; validIn = vld;
    model(op, a, b, r, ov, wr, c, h);
    #1;
    check(result == r, reqOf(op), "result", 32'(result), 32'(r));
    check(cost == c && handled == h, (h ? "R9" : "R10"), "cost/handled",
          {29'd0, handled, cost}, {29'd0, h, c});
    if (vld && h) begin
      if (dst) expOvf = r;
      else if (wr) expOvf = ov;
    end
    @(posedge clk);
    #1;
    check(ovfWord == expOvf, (!vld ? "R11" : dst ? "R12" : reqOf(op)), "ovfWord",
          32'(ovfWord), 32'(expOvf));
    validIn = 1'b0; dstIsOvf = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1;
    // R13 reset state
    check(ovfWord == 16'h0, "R13", "ovfWord after reset", 32'(ovfWord), 32'h0);
    @(negedge clk);
    rstN = 1'b1;

    // R1 carry edges
    doOp(4'h2, 16'hFFFF, 16'h0001, 0, 1);
    doOp(4'h2, 16'hFFFE, 16'h0001, 0, 1);
    // R2 borrow edges
    doOp(4'h3, 16'h0005, 16'h0006, 0, 1);
    doOp(4'h3, 16'h0007, 16'h0007, 0, 1);
    // R3
    doOp(4'h4, 16'hFFFF, 16'hFFFF, 0, 1);
    // R5 modulo keeps the word left by multiply, then zero divisor
    doOp(4'h6, 16'h1234, 16'h0000, 0, 1);
    doOp(4'h6, 16'h1234, 16'h0100, 0, 1);
    // R4 divide, zero divisor
    doOp(4'h5, 16'h0001, 16'h0003, 0, 1);
    doOp(4'h5, 16'hABCD, 16'h0000, 0, 1);
    // R6 shift left spill and large amounts
    doOp(4'h7, 16'h8421, 16'd4, 0, 1);
    doOp(4'h7, 16'h8421, 16'd20, 0, 1);
    doOp(4'h7, 16'h8421, 16'd32, 0, 1);
    // R7 shift right spill and large amounts
    doOp(4'h8, 16'h8421, 16'd4, 0, 1);
    doOp(4'h8, 16'h8421, 16'd31, 0, 1);
    doOp(4'h8, 16'h8421, 16'h0100, 0, 1);
    // R8 logic ops keep the overflow word
    doOp(4'h1, 16'h1111, 16'h2222, 0, 1);
    doOp(4'hB, 16'hF0F0, 16'h0FF0, 0, 1);
    // R10 unhandled opcodes, even with destination on overflow register
    doOp(4'h0, 16'h1111, 16'h2222, 1, 1);
    doOp(4'hD, 16'h1111, 16'h2222, 1, 1);
    // R11 strobe low
    doOp(4'h4, 16'h0100, 16'h0100, 0, 0);
    // R12 destination override on a flag-writing op
    doOp(4'h2, 16'hFFFF, 16'h0002, 1, 1);
    doOp(4'h9, 16'h00FF, 16'h0F0F, 1, 1);

    for (int i = 0; i < 400; i++) begin
      logic [3:0]  op;
      logic [15:0] a, b;
      op = 4'($urandom_range(0, 15));
      a  = 16'($urandom);
      case ($urandom_range(0, 3))
        0: b = 16'($urandom_range(0, 40));
        1: b = 16'h0;
        default: b = 16'($urandom);
      endcase
      doOp(op, a, b, ($urandom_range(0, 7) == 0), ($urandom_range(0, 5) != 0));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule